// File: doc/BRIEF.md
# Fully Associative Translation Cache with Status Write-Back

This block keeps recent page-to-frame translations in a small fully associative array. A lookup compares the incoming virtual page number with every valid entry at once. One cycle later the block answers with a hit, with a miss (the external table walker should then fetch the translation and fill it), or with a protection fault when a write reaches a page that is not writable.

Each entry keeps its own referenced and modified flags, which accesses update locally. An entry can leave the array in three ways: a fill replaces it, a single-page invalidate removes it, or a flush-all clears the whole array. When the entry leaving carries either flag, the block reports its page number and both flags on a one-cycle write-back output, so the page table can be brought up to date. The fill slot is chosen in this order: first a free slot, then the least recently used entry, tracked with a small saturating age counter on each entry.

Top module: `tlb_assoc_cache`

## Requirements
- R1: After synchronous active-low reset, every entry is invalid, and `rsp_valid`, `wb_valid`, `flush_busy` and `flush_done` are all 0.
- R2: An accepted lookup that matches a valid entry, and is either a read or a write to a writable page, gives `rsp_valid=1`, `rsp_hit=1`, and the stored frame and permissions on the cycle after it is accepted. Permission bits are bit0 read, bit1 write, bit2 execute.
- R3: An accepted lookup that matches no valid entry gives `rsp_valid=1`, `rsp_miss=1`, `rsp_hit=0` and `rsp_pfn=0` one cycle later.
- R4: A write lookup that matches an entry whose write bit (bit1) is clear gives `rsp_prot=1`, with `rsp_hit=0` and `rsp_miss=0`. It does not change that entry's referenced or modified flag.
- R5: A fill loads the referenced and modified flags from `fill_ref` and `fill_mod`. A read hit sets the referenced flag. A write hit sets both flags.
- R6: A fill of a new page takes the lowest-index invalid slot. When no slot is free, it replaces the entry with the greatest age, and a tie goes to the lowest index. A hit or a fill sets the age of the entry it touches to 0 and adds 1 to the age of every other valid entry, stopping at 2^AGE_W-1.
- R7: A fill whose page is already present overwrites that entry in place, so no page is ever held twice.
- R8: When an entry that is leaving (replaced by a fill, overwritten, or invalidated) has its referenced or modified flag set, the cycle after the operation shows a one-cycle `wb_valid` carrying its page and both flags. A clean entry produces no write-back.
- R9: An invalidate clears the matching entry, so later lookups of that page miss. An invalidate of a page that is absent has no effect.
- R10: An accepted flush clears every valid bit on its edge and raises `flush_busy`. Each entry that was valid and carries a flag is then reported, one per cycle, lowest index first. After the last report, `flush_done` pulses for one cycle and `flush_busy` falls.
- R11: Only one operation is accepted per cycle, in this priority: flush, then invalidate, then fill, then lookup. A lookup that loses to another operation gets no response. While `flush_busy` is high, flush, invalidate and fill requests are ignored, and lookups answer with a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vpn | input | VPN_W | Virtual page to translate |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_miss | output | 1 | No translation held |
| rsp_prot | output | 1 | Write to a page that is not writable |
| rsp_pfn | output | PFN_W | Frame number on hit, else 0 |
| rsp_perm | output | 3 | Permissions on hit (bit0 r, bit1 w, bit2 x) |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page of the fill |
| fill_pfn | input | PFN_W | Frame of the fill |
| fill_perm | input | 3 | Permissions of the fill |
| fill_ref | input | 1 | Initial referenced flag |
| fill_mod | input | 1 | Initial modified flag |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | VPN_W | Page to invalidate |
| flush_req | input | 1 | Invalidate every entry |
| flush_busy | output | 1 | Flush write-back reporting in progress |
| flush_done | output | 1 | One-cycle pulse at the end of a flush |
| wb_valid | output | 1 | Write-back report present |
| wb_vpn | output | VPN_W | Page of the departing entry |
| wb_ref | output | 1 | Its referenced flag |
| wb_mod | output | 1 | Its modified flag |

## Verification
The bench builds the block with ENTRIES=4, AGE_W=2, VPN_W=12 and PFN_W=10. With four slots the array fills after a few operations, so replacement starts almost at once. With a two-bit age, the counters saturate after three touches, which produces ties that only the lowest-index rule can settle. The small array also lets a flush report dirty entries in an order the bench can predict from the fill order.

// File: rtl/tlb_pkg.sv
// Package: types shared by the translation cache.
// Assumes: permission vectors are carried as {x, w, r}, with read in bit 0.
package tlb_pkg;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

endpackage

// File: rtl/tlb_first_set.sv
// Module: lowest-index set-bit finder.
// Assumes: N >= 1. idx is 0 when no bit is set; the caller qualifies it with any.
module tlb_first_set #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Scan downward so the lowest set index is the last one written
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/tlb_cam_match.sv
// Module: parallel page comparator over all entries.
// Assumes: the owner never holds one page twice, so at most one match bit is set.
module tlb_cam_match #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            match,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);

    // One comparator for each entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    tlb_first_set #(.N(ENTRIES), .IW(IDX_W)) u_enc (
        .vec (match),
        .any (any),
        .idx (idx)
    );

endmodule

// File: rtl/tlb_victim_sel.sv
// Module: replacement slot chooser.
// Picks the lowest free slot, or, when every slot is in use, the oldest entry;
// a tie on age goes to the lowest index.
// Assumes: ages of invalid slots are don't-care.
module tlb_victim_sel #(
    parameter int ENTRIES = 64,
    parameter int AGE_W   = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][AGE_W-1:0] ages,
    output logic [IDX_W-1:0]              idx
);

    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;
    logic [AGE_W-1:0] old_age;

    tlb_first_set #(.N(ENTRIES), .IW(IDX_W)) u_free (
        .vec (~valid),
        .any (free_any),
        .idx (free_idx)
    );

    // Strict greater-than keeps the lowest index on ties
    always_comb begin
        old_idx = '0;
        old_age = ages[0];
        for (int i = 1; i < ENTRIES; i++) begin
            if (ages[i] > old_age) begin
                old_age = ages[i];
                old_idx = IDX_W'(i);
            end
        end
    end

    // A free slot wins over any eviction
    always_comb idx = free_any ? free_idx : old_idx;

endmodule

// File: rtl/tlb_assoc_cache.sv
// Module: fully associative translation cache with referenced/modified tracking.
// Does: one-cycle registered lookup, fill with replacement, invalidate by page,
// flush-all with sequential reporting of dirty entries.
// Assumes: one operation per cycle, in the priority flush > invalidate > fill > lookup;
// the walker fills only after a miss, but a repeated page is overwritten in place.
module tlb_assoc_cache #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int AGE_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_prot,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic [2:0]       rsp_perm,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [2:0]       fill_perm,
    input  logic             fill_ref,
    input  logic             fill_mod,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_req,
    output logic             flush_busy,
    output logic             flush_done,
    output logic             wb_valid,
    output logic [VPN_W-1:0] wb_vpn,
    output logic             wb_ref,
    output logic             wb_mod
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    // Entry state
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
    logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
    tlb_pkg::perm_t [ENTRIES-1:0]   perm_q;
    logic [ENTRIES-1:0]             ref_q;
    logic [ENTRIES-1:0]             mod_q;
    logic [ENTRIES-1:0][AGE_W-1:0]  age_q;

    // Flush sequencing state
    logic               busy_q;
    logic               done_q;
    logic [ENTRIES-1:0] pend_q;
    logic               pend_any;
    logic [IDX_W-1:0]   pend_idx;

    // Operation arbitration
    logic acc_flush, acc_inv, acc_fill, acc_lk;
    logic [VPN_W-1:0]   cam_key;
    logic [ENTRIES-1:0] m_vec;
    logic               m_any;
    logic [IDX_W-1:0]   m_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic [IDX_W-1:0]   fill_tgt;
    tlb_pkg::perm_t     perm_m;
    logic               lk_deny;
    logic               lk_grant;
    logic               age_bump;
    logic [IDX_W-1:0]   age_tgt;

    // Decide which single operation this cycle carries out
    always_comb begin
        acc_flush = flush_req && !busy_q;
        acc_inv   = inv_valid && !flush_req && !busy_q;
        acc_fill  = fill_valid && !inv_valid && !flush_req && !busy_q;
        acc_lk    = lk_valid && !fill_valid && !inv_valid && !flush_req;
        cam_key   = inv_valid ? inv_vpn : (fill_valid ? fill_vpn : lk_vpn);
    end

    tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam (
        .valid (valid_q),
        .tags  (tag_q),
        .key   (cam_key),
        .match (m_vec),
        .any   (m_any),
        .idx   (m_idx)
    );

    tlb_victim_sel #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_vic (
        .valid (valid_q),
        .ages  (age_q),
        .idx   (vic_idx)
    );

    tlb_first_set #(.N(ENTRIES), .IW(IDX_W)) u_pend (
        .vec (pend_q),
        .any (pend_any),
        .idx (pend_idx)
    );

    // Derive the fill slot, the access verdict and the age update target
    always_comb begin
        fill_tgt = m_any ? m_idx : vic_idx;
        perm_m   = perm_q[m_idx];
        lk_deny  = acc_lk && m_any && lk_write && !perm_m.w;
        lk_grant = acc_lk && m_any && !lk_deny;
        age_bump = acc_fill || lk_grant;
        age_tgt  = acc_fill ? fill_tgt : m_idx;
    end

    // Valid bits: flush clears all, invalidate clears one, fill sets one
    always_ff @(posedge clk) begin
        if (!rst_n)                 valid_q <= '0;
        else if (acc_flush)         valid_q <= '0;
        else if (acc_inv && m_any)  valid_q[m_idx] <= 1'b0;
        else if (acc_fill)          valid_q[fill_tgt] <= 1'b1;
    end

    // Translation payload written on fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            pfn_q  <= '0;
            perm_q <= '0;
        end else if (acc_fill) begin
            tag_q[fill_tgt]  <= fill_vpn;
            pfn_q[fill_tgt]  <= fill_pfn;
            perm_q[fill_tgt] <= tlb_pkg::perm_t'(fill_perm);
        end
    end

    // Referenced and modified flags: loaded by fill, raised by granted accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            mod_q <= '0;
        end else if (acc_fill) begin
            ref_q[fill_tgt] <= fill_ref;
            mod_q[fill_tgt] <= fill_mod;
        end else if (lk_grant) begin
            ref_q[m_idx] <= 1'b1;
            if (lk_write) mod_q[m_idx] <= 1'b1;
        end
    end

    // Saturating ages: the touched entry restarts, the other valid ones grow older
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_bump) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == age_tgt)                 age_q[i] <= '0;
                else if (valid_q[i] && age_q[i] != AGE_MAX) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Flush sequencer: capture the dirty set, drain it, then pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            pend_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (acc_flush) begin
                busy_q <= 1'b1;
                pend_q <= valid_q & (ref_q | mod_q);
            end else if (busy_q) begin
                if (pend_any) begin
                    pend_q[pend_idx] <= 1'b0;
                end else begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Write-back report for an entry leaving with a flag set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_vpn   <= '0;
            wb_ref   <= 1'b0;
            wb_mod   <= 1'b0;
        end else begin
            wb_valid <= 1'b0;
            if (busy_q && pend_any) begin
                wb_valid <= 1'b1;
                wb_vpn   <= tag_q[pend_idx];
                wb_ref   <= ref_q[pend_idx];
                wb_mod   <= mod_q[pend_idx];
            end else if (acc_inv && m_any && (ref_q[m_idx] || mod_q[m_idx])) begin
                wb_valid <= 1'b1;
                wb_vpn   <= tag_q[m_idx];
                wb_ref   <= ref_q[m_idx];
                wb_mod   <= mod_q[m_idx];
            end else if (acc_fill && valid_q[fill_tgt] && (ref_q[fill_tgt] || mod_q[fill_tgt])) begin
                wb_valid <= 1'b1;
                wb_vpn   <= tag_q[fill_tgt];
                wb_ref   <= ref_q[fill_tgt];
                wb_mod   <= mod_q[fill_tgt];
            end
        end
    end

    // Registered lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_prot  <= 1'b0;
            rsp_pfn   <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= acc_lk;
            rsp_hit   <= lk_grant;
            rsp_miss  <= acc_lk && !m_any;
            rsp_prot  <= lk_deny;
            rsp_pfn   <= lk_grant ? pfn_q[m_idx] : '0;
            rsp_perm  <= lk_grant ? 3'(perm_m) : 3'b000;
        end
    end

    assign flush_busy = busy_q;
    assign flush_done = done_q;

    // R7: a page never sits in two entries
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_vec));

    // R2: every response carries exactly one outcome
    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_prot}) == 1));

    // R4: a denied write leaves the modified flags untouched
    p_prot_keeps_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_deny |=> (mod_q == $past(mod_q)));

    // R10: a flush leaves no valid entry behind
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_flush |=> (valid_q == '0));

    // R10: done ends a busy period
    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (!flush_busy && $past(flush_busy)));

    // R8: only flagged entries are reported
    p_wb_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_ref || wb_mod));

    // R11: no fill lands while a flush is draining
    p_busy_blocks_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> (valid_q == '0));

endmodule

// File: tb/tlb_assoc_cache_test.sv
`timescale 1ns/1ps
module tlb_assoc_cache_test;

    localparam int ENTRIES = 4;
    localparam int VPN_W   = 12;
    localparam int PFN_W   = 10;
    localparam int AGE_W   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0, lk_write = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             rsp_valid, rsp_hit, rsp_miss, rsp_prot;
    logic [PFN_W-1:0] rsp_pfn;
    logic [2:0]       rsp_perm;
    logic             fill_valid = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic [2:0]       fill_perm = '0;
    logic             fill_ref = 1'b0, fill_mod = 1'b0;
    logic             inv_valid = 1'b0;
    logic [VPN_W-1:0] inv_vpn = '0;
    logic             flush_req = 1'b0;
    logic             flush_busy, flush_done;
    logic             wb_valid, wb_ref, wb_mod;
    logic [VPN_W-1:0] wb_vpn;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    tlb_assoc_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .AGE_W(AGE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vpn(lk_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_prot(rsp_prot),
        .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .fill_ref(fill_ref), .fill_mod(fill_mod),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .flush_req(flush_req), .flush_busy(flush_busy), .flush_done(flush_done),
        .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_ref(wb_ref), .wb_mod(wb_mod)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic op_lookup(input logic [VPN_W-1:0] vpn, input logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic op_fill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                           input logic [2:0] perm, input logic r, input logic m);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
        fill_ref = r; fill_mod = m;
        @(negedge clk);
        fill_valid = 1'b0; fill_ref = 1'b0; fill_mod = 1'b0;
    endtask

    task automatic op_inv(input logic [VPN_W-1:0] vpn);
        @(negedge clk);
        inv_valid = 1'b1; inv_vpn = vpn;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn);
        op_lookup(vpn, 1'b0);
        chk({req, " hit"}, rsp_hit, 1);
        chk({req, " pfn"}, rsp_pfn, pfn);
    endtask

    task automatic expect_miss(input string req, input logic [VPN_W-1:0] vpn);
        op_lookup(vpn, 1'b0);
        chk({req, " miss"}, {rsp_valid, rsp_miss, rsp_hit}, 3'b110);
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 wb_valid", wb_valid, 0);
        chk("R1 busy/done", {flush_busy, flush_done}, 0);
        expect_miss("R1 empty", 12'h010);
    endtask

    // R2, R3: hits return frame and permissions, absent pages miss
    task automatic t_hit_miss();
        do_reset();
        op_fill(12'h010, 10'h101, 3'b001, 0, 0);
        op_fill(12'h020, 10'h202, 3'b111, 0, 0);
        op_lookup(12'h010, 1'b0);
        chk("R2 read hit", {rsp_valid, rsp_hit, rsp_miss, rsp_prot}, 4'b1100);
        chk("R2 pfn", rsp_pfn, 10'h101);
        chk("R2 perm", rsp_perm, 3'b001);
        op_lookup(12'h020, 1'b1);
        chk("R2 write hit", rsp_hit, 1);
        chk("R2 perm rwx", rsp_perm, 3'b111);
        op_lookup(12'h030, 1'b0);
        chk("R3 miss", {rsp_valid, rsp_miss, rsp_hit}, 3'b110);
        chk("R3 pfn zero", rsp_pfn, 0);
    endtask

    // R4: write to a page that is not writable
    task automatic t_prot();
        do_reset();
        op_fill(12'h040, 10'h044, 3'b001, 0, 0);
        op_lookup(12'h040, 1'b1);
        chk("R4 prot", {rsp_valid, rsp_prot, rsp_hit, rsp_miss}, 4'b1100);
        op_inv(12'h040);
        chk("R4 flags untouched", wb_valid, 0);
    endtask

    // R5, R8, R9: flags raised by access, reported on invalidate
    task automatic t_status();
        do_reset();
        op_fill(12'h0A0, 10'h0A, 3'b011, 0, 0);
        op_fill(12'h0B0, 10'h0B, 3'b001, 0, 0);
        op_fill(12'h0C0, 10'h0C, 3'b001, 0, 0);
        op_lookup(12'h0A0, 1'b1);
        op_lookup(12'h0B0, 1'b0);
        op_inv(12'h0A0);
        chk("R5 R8 write sets both", {wb_valid, wb_ref, wb_mod}, 3'b111);
        chk("R8 wb vpn", wb_vpn, 12'h0A0);
        op_inv(12'h0B0);
        chk("R5 read sets ref", {wb_valid, wb_ref, wb_mod}, 3'b110);
        op_inv(12'h0C0);
        chk("R8 clean no wb", wb_valid, 0);
        expect_miss("R9 after inv", 12'h0C0);
        op_inv(12'h0FF);
        chk("R9 absent inv", wb_valid, 0);
    endtask

    // R6, R8: free slot first, then oldest, ties to lowest index
    task automatic t_replace();
        do_reset();
        op_fill(12'h100, 10'h010, 3'b001, 0, 1);
        op_fill(12'h200, 10'h020, 3'b001, 0, 0);
        op_fill(12'h300, 10'h030, 3'b001, 0, 0);
        op_fill(12'h400, 10'h040, 3'b001, 0, 0);
        op_fill(12'h500, 10'h050, 3'b001, 0, 0);
        chk("R8 R5 evict dirty", {wb_valid, wb_ref, wb_mod}, 3'b101);
        chk("R6 oldest evicted", wb_vpn, 12'h100);
        expect_miss("R6 oldest gone", 12'h100);
        expect_hit("R6 newest", 12'h500, 10'h050);
        op_fill(12'h600, 10'h060, 3'b001, 0, 0);
        chk("R8 clean evict", wb_valid, 0);
        expect_miss("R6 tie lowest index", 12'h200);
        expect_hit("R6 tie keeps higher", 12'h300, 10'h030);
        expect_hit("R6 keeps", 12'h400, 10'h040);
        expect_hit("R6 new", 12'h600, 10'h060);
        do_reset();
        op_fill(12'h100, 10'h010, 3'b001, 0, 0);
        op_fill(12'h200, 10'h020, 3'b001, 0, 0);
        op_fill(12'h300, 10'h030, 3'b001, 0, 0);
        op_fill(12'h400, 10'h040, 3'b001, 0, 0);
        op_inv(12'h300);
        op_fill(12'h700, 10'h070, 3'b001, 0, 0);
        expect_hit("R6 free first a", 12'h100, 10'h010);
        expect_hit("R6 free first b", 12'h200, 10'h020);
        expect_hit("R6 free first c", 12'h400, 10'h040);
        expect_hit("R6 free first d", 12'h700, 10'h070);
    endtask

    // R7: refilling a present page replaces it in place
    task automatic t_overwrite();
        do_reset();
        op_fill(12'h0E0, 10'h111, 3'b001, 0, 1);
        op_fill(12'h0E0, 10'h222, 3'b001, 0, 0);
        chk("R7 old reported", {wb_valid, wb_mod}, 2'b11);
        expect_hit("R7 new frame", 12'h0E0, 10'h222);
    endtask

    // R11: arbitration between simultaneous requests
    task automatic t_priority();
        do_reset();
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 12'h0D0; fill_pfn = 10'h0D; fill_perm = 3'b001;
        lk_valid = 1'b1; lk_vpn = 12'h0D0;
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        chk("R11 lookup loses to fill", rsp_valid, 0);
        expect_hit("R11 fill taken", 12'h0D0, 10'h0D);
        @(negedge clk);
        inv_valid = 1'b1; inv_vpn = 12'h0D0;
        fill_valid = 1'b1; fill_vpn = 12'h0F0; fill_pfn = 10'h0F;
        @(negedge clk);
        inv_valid = 1'b0; fill_valid = 1'b0;
        expect_miss("R11 fill loses to inv", 12'h0F0);
        expect_miss("R11 inv taken", 12'h0D0);
    endtask

    // R10, R11: flush with dirty entries drained in index order
    task automatic t_flush();
        do_reset();
        op_fill(12'h011, 10'h001, 3'b001, 0, 1);
        op_fill(12'h022, 10'h002, 3'b001, 0, 0);
        op_fill(12'h033, 10'h003, 3'b001, 1, 0);
        op_fill(12'h044, 10'h004, 3'b001, 0, 0);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        chk("R10 busy", {flush_busy, wb_valid, flush_done}, 3'b100);
        lk_valid = 1'b1; lk_vpn = 12'h044;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R11 lookup during busy", {rsp_valid, rsp_miss}, 2'b11);
        chk("R10 first report", {wb_valid, wb_ref, wb_mod}, 3'b101);
        chk("R10 first vpn", wb_vpn, 12'h011);
        @(negedge clk);
        chk("R10 second report", {wb_valid, wb_ref, wb_mod, flush_done}, 4'b1100);
        chk("R10 second vpn", wb_vpn, 12'h033);
        @(negedge clk);
        chk("R10 done", {flush_done, flush_busy, wb_valid}, 3'b100);
        expect_miss("R10 cleared", 12'h022);
        // clean flush, with a fill attempted while busy
        do_reset();
        op_fill(12'h055, 10'h005, 3'b001, 0, 0);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        fill_valid = 1'b1; fill_vpn = 12'h066; fill_pfn = 10'h006; fill_perm = 3'b001;
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R10 clean done", {flush_done, flush_busy, wb_valid}, 3'b100);
        expect_miss("R11 fill ignored while busy", 12'h066);
        expect_miss("R10 clean cleared", 12'h055);
    endtask

    initial begin
        t_reset();
        t_hit_miss();
        t_prot();
        t_status();
        t_replace();
        t_overwrite();
        t_priority();
        t_flush();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule